// File: doc/BRIEF.md
# Tracking Set-Speed Memory

This block keeps a cruise set-point as a 9-bit binary count whose output is meant to feed a resistor-ladder converter. It does not load the measured speed directly. On a store request it clears the count, then raises it by one step on each oscillator enable pulse. A digital comparator stops the counting once the count reaches the measured speed code. The value then stays frozen, and the block flags it as valid.

An erase request clears the count and withdraws the valid flag. This is the path for power-up and ignition-off. A new store request always starts a fresh capture from zero, even when one is already running. A speed code at full scale ends the capture at 511 and the count does not wrap.

Top module: `spdmem_top`

## Requirements
- R1: After reset, memCode is 0, busy is 0 and valid is 0.
- R2: A store request (storeReq high at a rising edge, eraseReq low) sets memCode to 0 and busy to 1, and clears valid, from that edge on.
- R3: While busy is 1 and memCode is below speedCode, memCode rises by exactly one at each edge where tickEn is 1. It holds at edges where tickEn is 0.
- R4: At the first edge where busy is 1 and memCode is greater than or equal to speedCode, busy falls to 0 and valid rises to 1. With tickEn held at 1 from the store, this happens speedCode+1 cycles after the store edge, and memCode equals speedCode.
- R5: A speedCode of 511 (full scale) ends the capture with memCode at 511. The count never wraps to a smaller value except through a store or an erase.
- R6: A store request while busy is 1 restarts the capture: memCode returns to 0 and busy stays at 1.
- R7: An erase request sets memCode to 0, busy to 0 and valid to 0 at the next edge. It wins over a store request at the same edge.
- R8: After a completed capture, memCode holds its value regardless of changes on speedCode or tickEn, until the next store or erase.
- R9: valid is 0 whenever busy is 1. valid rises only at the end of a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Oscillator enable pulse; permits one count step |
| storeReq | input | 1 | Start a capture of the measured speed |
| eraseReq | input | 1 | Clear the stored speed (priority over store) |
| speedCode | input | 9 | Measured speed code |
| memCode | output | 9 | Stored count driving the ladder converter |
| busy | output | 1 | Capture in progress |
| valid | output | 1 | Stored value is the result of a completed capture |

## Verification
Several properties are checked on every cycle: busy and valid are never high together, and valid can rise only out of a busy cycle. Every count step adds exactly one, and the count never decreases without a clear. An erase empties all state, and the count stays still while idle. Other behaviour only shows up in the bench's scenarios: the exact capture latency for a range of speed codes, the stall when tickEn is low, the restart on a second store, the saturation at full scale, and the priority of erase over store.

// File: rtl/spdmem_pkg.sv
package spdmem_pkg;
  typedef struct packed {
    logic clearCnt;
    logic stepCnt;
  } dpCtrl_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_TRACK = 1'b1
  } capState_t;
endpackage

// File: rtl/spdmem_dp.sv
module spdmem_dp
  import spdmem_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtrl_t          ctrl,
  input  logic [WIDTH-1:0] speedCode,
  output logic [WIDTH-1:0] memCode,
  output logic             atTarget
);
  localparam logic [WIDTH-1:0] MAX_CODE = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cntQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (ctrl.clearCnt) begin
      cntQ <= '0;
    end else if (ctrl.stepCnt && cntQ != MAX_CODE) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign memCode  = cntQ;
  assign atTarget = (cntQ >= speedCode);

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.clearCnt |=> memCode >= $past(memCode));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.stepCnt |=> memCode == $past(memCode) + WIDTH'(1));
endmodule

// File: rtl/spdmem_ctrl.sv
module spdmem_ctrl
  import spdmem_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tickEn,
  input  logic    storeReq,
  input  logic    eraseReq,
  input  logic    atTarget,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    valid
);
  capState_t stateQ;
  logic      validQ;

  always_comb begin
    ctrl.clearCnt = eraseReq | storeReq;
    ctrl.stepCnt  = (stateQ == ST_TRACK) & ~ctrl.clearCnt & tickEn & ~atTarget;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      validQ <= 1'b0;
    end else if (eraseReq) begin
      stateQ <= ST_IDLE;
      validQ <= 1'b0;
    end else if (storeReq) begin
      stateQ <= ST_TRACK;
      validQ <= 1'b0;
    end else if (stateQ == ST_TRACK && atTarget) begin
      stateQ <= ST_IDLE;
      validQ <= 1'b1;
    end
  end

  assign busy  = (stateQ == ST_TRACK);
  assign valid = validQ;

  // R9
  busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && valid));

  // R4
  valid_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(busy));
endmodule

// File: rtl/spdmem_top.sv
module spdmem_top
  import spdmem_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             storeReq,
  input  logic             eraseReq,
  input  logic [WIDTH-1:0] speedCode,
  output logic [WIDTH-1:0] memCode,
  output logic             busy,
  output logic             valid
);
  dpCtrl_t dpCtrl;
  logic    atTarget;

  spdmem_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .storeReq (storeReq),
    .eraseReq (eraseReq),
    .atTarget (atTarget),
    .ctrl     (dpCtrl),
    .busy     (busy),
    .valid    (valid)
  );

  spdmem_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (dpCtrl),
    .speedCode (speedCode),
    .memCode   (memCode),
    .atTarget  (atTarget)
  );

  // R7
  erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |=> (memCode == '0 && !busy && !valid));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !storeReq && !eraseReq) |=> $stable(memCode));
endmodule

// File: tb/spdmem_top_bench.sv
module spdmem_top_bench;
  localparam int W = 9;
  localparam int NVEC = 6;
  localparam int unsigned SPEED_VEC [NVEC] = '{0, 1, 7, 100, 300, 511};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tickEn = 1'b0;
  logic         storeReq = 1'b0;
  logic         eraseReq = 1'b0;
  logic [W-1:0] speedCode = '0;
  logic [W-1:0] memCode;
  logic         busy;
  logic         valid;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  spdmem_top u_spdmem_top (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .storeReq(storeReq),
    .eraseReq(eraseReq), .speedCode(speedCode), .memCode(memCode),
    .busy(busy), .valid(valid)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doStore();
    storeReq = 1'b1;
    cyc();
    storeReq = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    cyc();
    cyc();
    // R1 reset state
    chk("R1 memCode", memCode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 valid", valid, 0);
    rst_n = 1'b1;
    cyc();

    // Table walk: R2, R4, R5, R9
    tickEn = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      speedCode = W'(SPEED_VEC[i]);
      doStore();
      chk("R2 memCode after store", memCode, 0);
      chk("R2 busy after store", busy, 1);
      chk("R9 valid during capture", valid, 0);
      n = 1;
      while (busy && n < 1000) begin
        cyc();
        n++;
        if (busy) chk("R9 valid low while busy", valid, 0);
      end
      chk("R4 capture latency", n - 1, int'(SPEED_VEC[i]) + 1);
      chk("R4 final code", memCode, int'(SPEED_VEC[i]));
      chk("R4 valid after capture", valid, 1);
    end
    chk("R5 saturated at full scale", memCode, 511);

    // R8 hold after capture
    speedCode = 9'd20;
    doStore();
    while (busy) cyc();
    speedCode = 9'd200;
    repeat (10) cyc();
    chk("R8 hold with higher speed", memCode, 20);
    speedCode = 9'd3;
    tickEn = 1'b0;
    repeat (3) cyc();
    chk("R8 hold with lower speed", memCode, 20);
    chk("R8 valid retained", valid, 1);

    // R3 stall with tickEn low
    speedCode = 9'd50;
    doStore();
    repeat (5) cyc();
    chk("R3 hold without tick", memCode, 0);
    chk("R3 busy while stalled", busy, 1);
    tickEn = 1'b1;
    cyc();
    tickEn = 1'b0;
    chk("R3 single step", memCode, 1);
    cyc();
    chk("R3 no step after tick drops", memCode, 1);
    tickEn = 1'b1;
    repeat (9) cyc();
    chk("R3 steady stepping", memCode, 10);

    // R6 restart
    doStore();
    chk("R6 restart clears count", memCode, 0);
    chk("R6 busy kept", busy, 1);
    repeat (4) cyc();
    chk("R6 counts from zero", memCode, 4);

    // R7 erase during busy, with store at same edge
    eraseReq = 1'b1;
    storeReq = 1'b1;
    cyc();
    eraseReq = 1'b0;
    storeReq = 1'b0;
    chk("R7 erase code", memCode, 0);
    chk("R7 erase busy", busy, 0);
    chk("R7 erase valid", valid, 0);
    repeat (3) cyc();
    chk("R7 stays erased", memCode, 0);

    // R7 erase after completed capture
    speedCode = 9'd5;
    doStore();
    while (busy) cyc();
    chk("R7 precondition valid", valid, 1);
    eraseReq = 1'b1;
    cyc();
    eraseReq = 1'b0;
    chk("R7 erase clears valid", valid, 0);
    chk("R7 erase clears stored code", memCode, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule